// File: doc/BRIEF.md
# Controller Output Port with Timed Low Pulse

This block keeps the 8-bit output port of a keyboard-style system controller. The host cannot address the port directly. It reaches the port only through controller commands, which a host interface block passes on as a command strobe with its byte and a data strobe with its argument byte. One command arms a write, and the next data byte then replaces the port contents. Another command returns the stored port value on a one-cycle read-back path.

A third group of commands drives chosen low-order port bits low for six microseconds and then lets them return to their stored levels. Port bit 0 is the active-low system reset line, so pulsing it resets the processor. Port bit 1 gates address line 20. Bits 4 and 5 carry the output-buffer-full and input-buffer-empty indications. Bits 6 and 7 carry the keyboard clock and data outputs.

The pulse length is derived from a clock-frequency parameter. While a pulse runs, a busy flag is raised. Pulse and port-write commands that arrive during a pulse are dropped.

Top module: `outport_pulse`

## Requirements
- R1: After reset the stored port is 8'h03 (reset line released, address gate 20 enabled), busy is low and the read-back valid is low.
- R2: Command 8'hD1 arms a write. The next data strobe loads its byte into the port, visible on the cycle after that strobe. A data strobe with no armed write leaves the port unchanged.
- R3: Command 8'hD0 raises the read-back valid for exactly one cycle, on the cycle after the command, carrying the stored port value.
- R4: A command whose upper nibble is 4'hF pulses port bit i (for i in 0..3) when command bit i is 0. Bit i stays unchanged when command bit i is 1. Bits 4 to 7 are never pulsed.
- R5: A pulse holds the selected bits low for exactly PULSE_US times CLK_HZ/1e6 cycles (750 at 125 MHz, 6 us). The bits then return to their stored levels.
- R6: Busy is high exactly while a pulse is driven. Command 8'hFF selects no bit and raises no busy.
- R7: While busy, a pulse command or an 8'hD1 command is ignored: the pulse is not lengthened or restarted, and a following data byte is not loaded.
- R8: The reset-line output always equals driven port bit 0, and the address-gate output always equals driven port bit 1.
- R9: Any command that arrives between 8'hD1 and its data byte cancels the armed write.
- R10: Read-back during a pulse returns the stored levels, not the pulsed ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_byte_i | input | 8 | Command byte |
| data_valid_i | input | 1 | Data strobe |
| data_byte_i | input | 8 | Argument byte |
| rd_valid_o | output | 1 | Read-back byte valid |
| rd_data_o | output | 8 | Read-back byte (stored port) |
| port_o | output | 8 | Driven port value, pulse applied |
| sys_reset_no | output | 1 | Active-low system reset line (port bit 0) |
| a20_gate_o | output | 1 | Address line 20 gate (port bit 1) |
| busy_o | output | 1 | Pulse in progress |

## Verification
All 16 pulse masks are tried on an all-ones port. Each mask is tried again on a mixed stored pattern, which separates pulsed bits from bits that were already low and shows that the upper nibble never moves. All 256 data bytes are written and read back, which exposes bit swaps in the load and read paths. Commands injected in the middle of a pulse separate "ignored" from "restarted": a restart would stretch the measured low time past 750 cycles, and a late write would change the restored value.

// File: rtl/outport_pkg.sv
package outport_pkg;
    localparam int PORT_W  = 8;
    localparam int PULSE_W = 4;

    localparam logic [7:0] CMD_PORT_READ  = 8'hD0;
    localparam logic [7:0] CMD_PORT_WRITE = 8'hD1;
    localparam logic [3:0] CMD_PULSE_TAG  = 4'hF;

    typedef struct packed {
        logic               any_cmd;
        logic               rd;
        logic               wr_arm;
        logic               pulse;
        logic [PULSE_W-1:0] sel;
    } port_req_t;
endpackage

// File: rtl/op_cmd_decode.sv
module op_cmd_decode
    import outport_pkg::*;
(
    input  logic       cmd_valid_i,
    input  logic [7:0] cmd_byte_i,
    output port_req_t  req_o
);
    logic [PULSE_W-1:0] sel_w;

    always_comb begin
        // zero in the command selects the bit
        sel_w          = ~cmd_byte_i[PULSE_W-1:0];
        req_o          = '0;
        req_o.any_cmd  = cmd_valid_i;
        req_o.rd       = cmd_valid_i && (cmd_byte_i == CMD_PORT_READ);
        req_o.wr_arm   = cmd_valid_i && (cmd_byte_i == CMD_PORT_WRITE);
        req_o.pulse    = cmd_valid_i && (cmd_byte_i[7:4] == CMD_PULSE_TAG) && (sel_w != '0);
        req_o.sel      = sel_w;
    end

    always_comb begin
        assert (!(req_o.rd && req_o.wr_arm)) else $error("p_one_request_r3");
    end
endmodule

// File: rtl/op_pulse_timer.sv
module op_pulse_timer
    import outport_pkg::*;
#(
    parameter int PULSE_CYC = 750
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic [PULSE_W-1:0] sel_i,
    output logic               busy_o,
    output logic [PULSE_W-1:0] mask_o
);
    localparam int CNT_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC - 1);

    typedef struct packed {
        logic               busy;
        logic [CNT_W-1:0]   cnt;
        logic [PULSE_W-1:0] mask;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (s_q.cnt == '0) begin
                s_d.busy = 1'b0;
                s_d.mask = '0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else if (start_i) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CNT_LOAD;
            s_d.mask = sel_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign busy_o = s_q.busy;
    assign mask_o = s_q.mask;

    p_busy_has_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.busy |-> (s_q.mask != '0));
    p_count_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.busy |-> (32'(s_q.cnt) < PULSE_CYC));
    p_start_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.busy) |-> (s_q.cnt == CNT_LOAD));
    p_no_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.busy && s_q.cnt != '0) |=> (s_q.busy && $stable(s_q.mask)));
endmodule

// File: rtl/op_port_reg.sv
module op_port_reg
    import outport_pkg::*;
#(
    parameter logic [PORT_W-1:0] PORT_RST = 8'h03
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  port_req_t         req_i,
    input  logic              busy_i,
    input  logic              data_valid_i,
    input  logic [PORT_W-1:0] data_byte_i,
    output logic [PORT_W-1:0] port_q_o,
    output logic              rd_valid_o,
    output logic [PORT_W-1:0] rd_data_o
);
    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic              armed;
        logic              rd_valid;
        logic [PORT_W-1:0] rd_data;
    } preg_t;

    preg_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.rd_valid = 1'b0;
        if (req_i.any_cmd) begin
            // a fresh command always replaces a pending argument wait
            s_d.armed = req_i.wr_arm && !busy_i;
        end else if (data_valid_i && s_q.armed) begin
            s_d.port  = data_byte_i;
            s_d.armed = 1'b0;
        end
        if (req_i.rd) begin
            s_d.rd_valid = 1'b1;
            s_d.rd_data  = s_q.port;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.port     <= PORT_RST;
            s_q.armed    <= 1'b0;
            s_q.rd_valid <= 1'b0;
            s_q.rd_data  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign port_q_o   = s_q.port;
    assign rd_valid_o = s_q.rd_valid;
    assign rd_data_o  = s_q.rd_data;

    p_port_frozen_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |=> $stable(s_q.port));
    p_never_armed_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |=> !s_q.armed);
    p_load_needs_arm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !s_q.armed |=> $stable(s_q.port));
endmodule

// File: rtl/outport_pulse.sv
module outport_pulse
    import outport_pkg::*;
#(
    parameter longint CLK_HZ   = 125_000_000,
    parameter int     PULSE_US = 6,
    parameter logic [7:0] PORT_RST = 8'h03
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       cmd_valid_i,
    input  logic [7:0] cmd_byte_i,
    input  logic       data_valid_i,
    input  logic [7:0] data_byte_i,
    output logic       rd_valid_o,
    output logic [7:0] rd_data_o,
    output logic [7:0] port_o,
    output logic       sys_reset_no,
    output logic       a20_gate_o,
    output logic       busy_o
);
    localparam int PULSE_CYC = int'((CLK_HZ / 64'd1_000_000) * longint'(PULSE_US));

    port_req_t          req_w;
    logic               busy_w;
    logic [PULSE_W-1:0] mask_w;
    logic [PORT_W-1:0]  port_q_w;
    logic [PORT_W-1:0]  drive_mask_w;

    op_cmd_decode u_dec (
        .cmd_valid_i (cmd_valid_i),
        .cmd_byte_i  (cmd_byte_i),
        .req_o       (req_w)
    );

    op_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_tmr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (req_w.pulse),
        .sel_i   (req_w.sel),
        .busy_o  (busy_w),
        .mask_o  (mask_w)
    );

    op_port_reg #(.PORT_RST(PORT_RST)) u_preg (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .req_i        (req_w),
        .busy_i       (busy_w),
        .data_valid_i (data_valid_i),
        .data_byte_i  (data_byte_i),
        .port_q_o     (port_q_w),
        .rd_valid_o   (rd_valid_o),
        .rd_data_o    (rd_data_o)
    );

    always_comb begin
        drive_mask_w = '0;
        drive_mask_w[PULSE_W-1:0] = busy_w ? mask_w : '0;
        port_o       = port_q_w & ~drive_mask_w;
        sys_reset_no = port_o[0];
        a20_gate_o   = port_o[1];
        busy_o       = busy_w;
    end

    p_upper_untouched_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        port_o[PORT_W-1:PULSE_W] == port_q_w[PORT_W-1:PULSE_W]);
    p_idle_drives_stored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (port_o == port_q_w));
    p_read_follows_cmd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o |-> $past(cmd_valid_i && cmd_byte_i == CMD_PORT_READ));
endmodule

// File: tb/outport_pulse_tb.sv
module outport_pulse_tb;
    localparam int PULSE_CYC = 750;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = '0;
    logic       data_valid = 1'b0;
    logic [7:0] data_byte = '0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic [7:0] port;
    logic       sys_rst_n;
    logic       a20;
    logic       busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    outport_pulse u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .cmd_valid_i(cmd_valid), .cmd_byte_i(cmd_byte),
        .data_valid_i(data_valid), .data_byte_i(data_byte),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data),
        .port_o(port), .sys_reset_no(sys_rst_n), .a20_gate_o(a20), .busy_o(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [7:0] b);
        @(negedge clk); cmd_valid = 1'b1; cmd_byte = b;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic send_data(input logic [7:0] b);
        @(negedge clk); data_valid = 1'b1; data_byte = b;
        @(negedge clk); data_valid = 1'b0;
    endtask

    task automatic write_port(input logic [7:0] v);
        send_cmd(8'hD1);
        send_data(v);
    endtask

    // returns number of cycles busy stays high, sampled from the current negedge
    task automatic wait_idle(input int t0, output int dur);
        int guard = 0;
        while (busy && guard < 5000) begin
            @(negedge clk); guard++;
        end
        dur = cyc - t0;
    endtask

    task automatic pulse_case(input logic [7:0] v, input logic [3:0] m);
        logic [7:0] exp_low;
        int t0, dur;
        write_port(v);
        exp_low = v & ~{4'h0, ~m};
        send_cmd({4'hF, m});
        t0 = cyc;
        check(port == exp_low, "R4 pulsed levels", port, exp_low);
        check(sys_rst_n == exp_low[0] && a20 == exp_low[1], "R8 line outputs",
              {sys_rst_n, a20}, {exp_low[0], exp_low[1]});
        check(busy == (m != 4'hF), "R6 busy during pulse", busy, (m != 4'hF));
        wait_idle(t0, dur);
        check(dur == ((m == 4'hF) ? 0 : PULSE_CYC), "R5 pulse length", dur,
              (m == 4'hF) ? 0 : PULSE_CYC);
        check(port == v && !busy, "R5 restore", port, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int t0, dur;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(port == 8'h03, "R1 reset port", port, 8'h03);
        check(!busy && !rd_valid, "R1 reset flags", {busy, rd_valid}, 0);
        check(sys_rst_n && a20, "R8 reset lines", {sys_rst_n, a20}, 2'b11);

        // R2 data without armed write ignored
        send_data(8'h5A);
        check(port == 8'h03, "R2 unarmed data ignored", port, 8'h03);

        // R2/R3 all byte values
        for (int v = 0; v < 256; v++) begin
            write_port(8'(v));
            check(port == 8'(v), "R2 write port", port, v);
            send_cmd(8'hD0);
            check(rd_valid && rd_data == 8'(v), "R3 read-back", rd_data, v);
            @(negedge clk);
            check(!rd_valid, "R3 single cycle valid", rd_valid, 0);
        end

        // R9 intervening command cancels armed write
        write_port(8'h3C);
        send_cmd(8'hD1);
        send_cmd(8'hD0);
        send_data(8'hC3);
        check(port == 8'h3C, "R9 cancel armed write", port, 8'h3C);

        // R4/R5/R6/R8 every mask on two stored patterns
        for (int m = 0; m < 16; m++) pulse_case(8'hFF, 4'(m));
        for (int m = 0; m < 16; m++) pulse_case(8'hA6, 4'(m));

        // R7/R10 commands during a pulse
        write_port(8'hFF);
        send_cmd(8'hF0);
        t0 = cyc;
        repeat (100) @(negedge clk);
        send_cmd(8'hD1);
        send_data(8'h00);
        check(port == 8'hF0, "R7 write ignored while busy", port, 8'hF0);
        send_cmd(8'hF0);
        send_cmd(8'hD0);
        check(rd_valid && rd_data == 8'hFF, "R10 read stored during pulse", rd_data, 8'hFF);
        wait_idle(t0, dur);
        check(dur == PULSE_CYC, "R7 pulse not restarted", dur, PULSE_CYC);
        check(port == 8'hFF, "R7 restored unchanged", port, 8'hFF);
        send_data(8'h00);
        check(port == 8'hFF, "R7 no arm left after pulse", port, 8'hFF);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule